// File: doc/BRIEF.md
# Serial Link Transmit Datapath

This block is the digital front end of a high-speed serial transmitter. It runs entirely on the fast serial clock. A 20-bit parallel word is taken in once per reference period, and its bits are shifted out one per fast cycle, most significant bit first. The moment of capture is set by a load strobe. A free-running fast-clock counter makes this strobe, and the counter is re-aligned to every rising edge of the reference clock. The reference clock reaches the block as a level that is synchronous to the fast clock.

A 2-bit source select picks what drives the line. The choices are the serializer stream, the output of an 8-bit maximal-length pseudo-random generator, an alternating 1/0 pattern, or a word-boundary marker. The chosen bit is registered as the main tap. A second output, the post tap, carries the main tap inverted and delayed by one to four fast cycles. The two taps feed the positive-weight and negative-weight stages of a first-order pre-emphasis output driver.

Top module: `sertx_path`

## Requirements
- R1: A fast-clock edge with `rst_n` low sets `tap_main` to 0 and `tap_post` to 1, and seeds the generator with 8'h01. With `src_sel`=01 held through reset, the first seven `tap_main` samples after release are 0 and the eighth is 1.
- R2: The word present on `word_in` is loaded at the fast edge that follows the edge on which a rising `ref_clk` is first sampled. With no new rising edge, a load recurs exactly every 20 fast cycles.
- R3: With `src_sel`=00, the bit `tap_main` shows after the edge following a load is bit 19 of the loaded word. Each later edge shows the next lower bit, so a whole word is sent in 20 cycles.
- R4: Values on `word_in` at edges other than the load edge have no effect on the serial output.
- R5: `src_sel` codes: 00 serializer, 01 pseudo-random, 10 alternating pattern, 11 load marker. The chosen bit reaches `tap_main` one edge later.
- R6: The pseudo-random stream obeys s[n] = s[n-4] ^ s[n-5] ^ s[n-6] ^ s[n-8] (polynomial x^8+x^6+x^5+x^4+1). It repeats every 255 bits, with no shorter period, and holds 128 ones per period.
- R7: With `src_sel`=10, `tap_main` changes value on every fast edge.
- R8: With `src_sel`=11, `tap_main` is 1 exactly for the cycle after each load edge and 0 otherwise.
- R9: `tap_post` equals the inverse of `tap_main` as it was D edges earlier, where D = 4 − `dly_code`. Code 11 gives 1 cycle and code 00 gives 4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast serial clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk_fast` |
| ref_clk | input | 1 | Reference clock level, synchronous to `clk_fast`, period 20 fast cycles |
| word_in | input | 20 | Parallel word to transmit |
| src_sel | input | 2 | Output source select |
| dly_code | input | 2 | Post-tap delay code |
| tap_main | output | 1 | Main (positive-weight) driver bit |
| tap_post | output | 1 | Delayed inverted (negative-weight) driver bit |

## Verification
Two events can fall on the same edge: the sampled rising edge of the reference clock, and the counter wrapping from 19 to 0. If these two moves are out of step, a load lands twice or at a shifted phase. The bench drives a steady 20-cycle reference, so the re-alignment and the wrap coincide on every word. It judges the result by checking that each word's 20 bits appear MSB first with no slip at the word seams, while `word_in` is scrambled on every non-load edge. It then holds the reference low and checks that the load marker still recurs every 20 cycles on the wrap alone.

// File: rtl/sertx_path.sv
module sertx_path #(
  parameter int          WORD_W    = 20,
  parameter logic [7:0]  LFSR_SEED = 8'h01
) (
  input  logic              clk_fast,
  input  logic              rst_n,
  input  logic              ref_clk,
  input  logic [WORD_W-1:0] word_in,
  input  logic [1:0]        src_sel,
  input  logic [1:0]        dly_code,
  output logic              tap_main,
  output logic              tap_post
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

  logic              ref_q;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] shreg;
  logic [7:0]        lfsr;
  logic              alt;
  logic [3:0]        hist;
  logic              src_bit;

  wire ref_rise = ref_clk & ~ref_q;
  wire load     = (cnt == '0);
  wire lfsr_fb  = lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3];

  always_comb begin
    case (src_sel)
      2'b00:   src_bit = shreg[WORD_W-1];
      2'b01:   src_bit = lfsr[7];
      2'b10:   src_bit = alt;
      default: src_bit = load;
    endcase
  end

  always_ff @(posedge clk_fast) begin
    if (!rst_n) begin
      ref_q    <= 1'b0;
      cnt      <= '0;
      shreg    <= '0;
      lfsr     <= LFSR_SEED;
      alt      <= 1'b0;
      tap_main <= 1'b0;
      hist     <= '0;
    end else begin
      ref_q <= ref_clk;
      if (ref_rise || cnt == CNT_LAST) cnt <= '0;
      else                             cnt <= cnt + 1'b1;
      shreg    <= load ? word_in : {shreg[WORD_W-2:0], 1'b0};
      lfsr     <= {lfsr[6:0], lfsr_fb};
      alt      <= ~alt;
      tap_main <= src_bit;
      hist     <= {hist[2:0], tap_main};
    end
  end

  assign tap_post = ~hist[2'd3 - dly_code];
endmodule

// File: rtl/sertx_path_chk.sv
module sertx_path_chk #(
  parameter int WORD_W = 20,
  parameter int CNT_W  = 5
) (
  input logic             clk_fast,
  input logic             rst_n,
  input logic             ref_clk,
  input logic             ref_q,
  input logic [CNT_W-1:0] cnt,
  input logic             load,
  input logic [7:0]       lfsr,
  input logic [1:0]       src_sel,
  input logic [1:0]       dly_code,
  input logic             tap_main,
  input logic             tap_post
);
  assert_reset_out_R1: assert property (@(posedge clk_fast)
    !rst_n |=> (tap_main == 1'b0 && tap_post == 1'b1));

  assert_cnt_range_R2: assert property (@(posedge clk_fast) disable iff (!rst_n)
    cnt <= CNT_W'(WORD_W - 1));

  assert_realign_R2: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (ref_clk && !ref_q) |=> load);

  assert_lfsr_live_R6: assert property (@(posedge clk_fast) disable iff (!rst_n)
    lfsr != 8'h00);

  assert_marker_R8: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (src_sel == 2'b11 && load) |=> tap_main);

  assert_post_short_R9: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (dly_code == 2'b11) |-> (tap_post == ~$past(tap_main)));
endmodule

bind sertx_path sertx_path_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk_fast(clk_fast), .rst_n(rst_n), .ref_clk(ref_clk), .ref_q(ref_q),
  .cnt(cnt), .load(load), .lfsr(lfsr), .src_sel(src_sel),
  .dly_code(dly_code), .tap_main(tap_main), .tap_post(tap_post)
);

// File: tb/sertx_path_tb.sv
module sertx_path_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n    = 1'b0;
  logic        ref_clk  = 1'b0;
  logic [19:0] word_in  = '0;
  logic [1:0]  src_sel  = 2'b00;
  logic [1:0]  dly_code = 2'b11;
  logic        tap_main, tap_post;

  int n_run  = 0;
  int n_fail = 0;
  int ph     = 0;

  sertx_path u_dut (
    .clk_fast(clk), .rst_n(rst_n), .ref_clk(ref_clk), .word_in(word_in),
    .src_sel(src_sel), .dly_code(dly_code), .tap_main(tap_main), .tap_post(tap_post)
  );

  localparam logic [21:0] VEC [0:8] = '{
    {2'd3, 20'hA5F0C}, {2'd3, 20'h12345}, {2'd0, 20'hFFFFF},
    {2'd1, 20'h00001}, {2'd2, 20'h80000}, {2'd0, 20'hCCCCC},
    {2'd2, 20'h3C3C3}, {2'd1, 20'h00000}, {2'd3, 20'h7E817}
  };

  task automatic tick(input logic [19:0] w, input bit ref_on);
    @(negedge clk);
    ref_clk = ref_on && (ph < 10);
    word_in = (ph == 1) ? w : (w ^ 20'h5A5A5 ^ 20'(ph * 7919));
    @(posedge clk);
    #1;
    ph = (ph == 19) ? 0 : ph + 1;
  endtask

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  logic        bits [0:509];
  logic [19:0] prevw;
  logic        eh [0:3];

  initial begin
    int n = 0;
    logic e;
    // R1 reset state
    for (int i = 0; i < 4; i++) tick(20'h0, 0);
    chk(tap_main == 1'b0, "R1 main", tap_main, 0);
    chk(tap_post == 1'b1, "R1 post", tap_post, 1);
    ph = 0;
    rst_n = 1'b1;
    prevw = '0;
    // R2 R3 R4 R9: vector table
    for (int k = 0; k < 9; k++) begin
      logic [19:0] w;
      w = VEC[k][19:0];
      dly_code = VEC[k][21:20];
      for (int t = 0; t < 20; t++) begin
        tick(w, 1);
        if (k > 0 || t >= 2) begin
          e = (t >= 2) ? w[21-t] : prevw[1-t];
          chk(tap_main == e, "R3/R4 serial bit", tap_main, e);
          if (n >= 4) begin
            int d;
            d = 4 - int'(dly_code);
            chk(tap_post == ~eh[d-1], "R9 post tap", tap_post, ~eh[d-1]);
          end
          eh[3] = eh[2]; eh[2] = eh[1]; eh[1] = eh[0]; eh[0] = e;
          n++;
        end
      end
      prevw = w;
    end
    // R8 marker with reference running (R2 phase)
    src_sel = 2'b11;
    tick(20'h0, 1);
    while (ph != 0) tick(20'h0, 1);
    for (int i = 0; i < 40; i++) begin
      int t;
      t = ph;
      tick(20'h0, 1);
      chk(tap_main == (t == 1), "R8 marker", tap_main, t == 1);
    end
    // R2 free-running load with reference held low
    begin
      int cnt1 = 0, last = -1, gap_bad = 0;
      for (int i = 0; i < 60; i++) begin
        tick(20'h0, 0);
        if (tap_main) begin
          if (last >= 0 && i - last != 20) gap_bad++;
          last = i;
          cnt1++;
        end
      end
      chk(cnt1 == 3, "R2 loads without ref", cnt1, 3);
      chk(gap_bad == 0, "R2 load spacing", gap_bad, 0);
    end
    // R5 R7 alternating source
    src_sel = 2'b10;
    tick(20'h0, 1);
    begin
      logic p;
      p = tap_main;
      for (int i = 0; i < 20; i++) begin
        tick(20'h0, 1);
        chk(tap_main != p, "R7 alternating", tap_main, ~p);
        p = tap_main;
      end
    end
    // R5 R6 pseudo-random source
    src_sel = 2'b01;
    tick(20'h0, 1);
    tick(20'h0, 1);
    for (int i = 0; i < 510; i++) begin
      tick(20'h0, 1);
      bits[i] = tap_main;
    end
    begin
      int rec_bad = 0, per_bad = 0, ones = 0;
      int d15 = 0, d51 = 0, d85 = 0;
      for (int i = 8; i < 510; i++)
        if (bits[i] != (bits[i-4] ^ bits[i-5] ^ bits[i-6] ^ bits[i-8])) rec_bad++;
      for (int i = 0; i < 255; i++) begin
        if (bits[i] != bits[i+255]) per_bad++;
        if (bits[i]) ones++;
        if (bits[i] != bits[i+15]) d15++;
        if (bits[i] != bits[i+51]) d51++;
        if (bits[i] != bits[i+85]) d85++;
      end
      chk(rec_bad == 0, "R6 recurrence", rec_bad, 0);
      chk(per_bad == 0, "R6 period 255", per_bad, 0);
      chk(ones == 128, "R6 ones per period", ones, 128);
      chk(d15 > 0 && d51 > 0 && d85 > 0, "R6 no shorter period", d15 * d51 * d85, 1);
    end
    // R1 mid-stream reset and generator seed
    rst_n = 1'b0;
    tick(20'h0, 1);
    tick(20'h0, 1);
    chk(tap_main == 1'b0, "R1 main after reset", tap_main, 0);
    chk(tap_post == 1'b1, "R1 post after reset", tap_post, 1);
    rst_n = 1'b1;
    for (int i = 1; i <= 8; i++) begin
      tick(20'h0, 0);
      chk(tap_main == (i == 8), "R1 seed output", tap_main, i == 8);
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #250000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule